// File: doc/BRIEF.md
# Emulated UART Line Status Logic

This block holds the receive and transmit status logic of a 16550-style register set whose far end is an embedded controller rather than a serial shifter. The controller plays the line. It writes received characters, it can plant parity, framing and break flags, and it drains the bytes the host queues for transmission. The host reads received bytes and the line status byte, and writes transmit bytes.

The receive side is a single holding register in character mode and a small FIFO in FIFO mode. Each FIFO entry keeps its own three error flags next to the data byte. The transmit side is the same kind of store, and its empty flag follows a fill-level hysteresis in FIFO mode. The data-ready and transmit-empty flags can each be delayed for the host by a programmable down-counter. The controller always sees the undelayed copies on its own status output.

Top module: `uart_lsr_emu`

## Requirements
- R1: After reset, with both timers disabled, both status outputs read 0x60 (bits 6 and 5 set, all others clear) and the transmit level is 0.
- R2: With the receive timer disabled, bit 0 is set at the first clock edge that accepts a controller character. It clears at the edge where the host reads the last stored byte.
- R3: A controller character arriving while the store is full is discarded and sets bit 1. In character mode the store holds 1 byte and in FIFO mode it holds RX_DEPTH bytes. The byte already held stays readable.
- R4: Bit 1 clears at the edge of a host status read, unless a new overrun occurs in the same cycle.
- R5: A controller status write loads flags into a shadow: flag bit 2 is break, bit 1 is framing and bit 0 is parity, and they appear at status bits 4, 3 and 2. The next controller character carries the shadow with it, and the shadow then clears, so the character after that arrives clean.
- R6: Status bits 4..2 show the flags of the byte at the head of the store. In FIFO mode bit 7 is 1 while any stored byte has a nonzero flag, and it clears when the last such byte is read. In character mode bit 7 is 0.
- R7: In character mode, bit 5 (and bit 6, which always equals it) is 0 after a host transmit write and returns to 1 once the controller takes the byte.
- R8: In FIFO mode, bit 5 stays 1 until the transmit level reaches the trigger level. The trigger select is 0:1, 1:4, 2:8 and 3:14. Bit 5 then stays 0 until the level is 0 again.
- R9: With the receive timer enabled and reload value N, host bit 0 rises N+1 cycles after the controller copy. Each accepted character that arrives while the host bit is still pending restarts the count. The host bit never reads 1 while the controller copy is 0.
- R10: With the transmit timer enabled and reload value N, host bit 5 rises N+1 cycles after the controller copy. It never reads 1 while the controller copy is 0.
- R11: The host receives the bytes in the order the controller wrote them, and the controller receives the transmit bytes in the order the host wrote them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects character mode |
| tx_trig_sel | input | 2 | Transmit trigger level select |
| rx_tmr_en | input | 1 | Enables the data-ready delay for the host |
| rx_tmr_reload | input | TMR_W | Reload value of the receive delay |
| tx_tmr_en | input | 1 | Enables the transmit-empty delay for the host |
| tx_tmr_reload | input | TMR_W | Reload value of the transmit delay |
| host_tx_wr | input | 1 | Host writes a transmit byte |
| host_tx_data | input | 8 | Host transmit byte |
| host_rx_rd | input | 1 | Host reads the head receive byte |
| host_lsr_rd | input | 1 | Host reads the status byte |
| host_rx_data | output | 8 | Head receive byte |
| host_lsr | output | 8 | Status byte as the host sees it |
| ctl_rx_wr | input | 1 | Controller writes a received character |
| ctl_rx_data | input | 8 | Received character |
| ctl_lsr_wr | input | 1 | Controller loads the shadow error flags |
| ctl_err_flags | input | 3 | Break, framing and parity flags |
| ctl_tx_rd | input | 1 | Controller takes the head transmit byte |
| ctl_tx_data | output | 8 | Head transmit byte |
| ctl_tx_level | output | $clog2(TX_DEPTH+1) | Transmit bytes stored |
| ctl_lsr | output | 8 | Status byte with undelayed bits 0, 5 and 6 |

## Verification
A wrong occupancy count shows at the ports within one character. It either drops a byte or sends a false overrun, and the overrun appears as bit 1 on the next cycle. An error counter that falls out of step leaves bit 7 stuck after the last flagged byte has been read. That is visible at the very next sample. A shadow that does not clear stamps its flags onto the following character, and the head-flag check catches this when that byte reaches the head. A timer that reloads at the wrong moment moves the host bit by whole cycles, so the delay checks sample exactly one cycle before and one cycle at the expected rise.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
   localparam int DW = 8;
   localparam int EW = 3;

   typedef struct packed {
      logic [EW-1:0] err;   // [2] break, [1] framing, [0] parity
      logic [DW-1:0] data;
   } rx_ent_t;

   function automatic logic [4:0] trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 5'd1;
         2'd1:    return 5'd4;
         2'd2:    return 5'd8;
         default: return 5'd14;
      endcase
   endfunction
endpackage

// File: rtl/lsr_fifo.sv
module lsr_fifo #(
   parameter  int W     = 8,
   parameter  int DEPTH = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lsr_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + AW'(1);
         if (pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assign dout = mem[rd_ptr];
endmodule

// File: rtl/lsr_delay.sv
module lsr_delay #(
   parameter int HAS_TMR = 1,
   parameter int TMR_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [TMR_W-1:0] reload,
   input  logic             src,
   input  logic             restart,
   output logic             out
);
   if (HAS_TMR != 0) begin : g_tmr
      logic [TMR_W-1:0] cnt;
      logic             hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
            hit <= 1'b0;
         end else if (!src) begin
            cnt <= reload;
            hit <= 1'b0;
         end else if (restart && !hit) begin
            cnt <= reload;
         end else if (cnt != '0) begin
            cnt <= cnt - TMR_W'(1);
         end else begin
            hit <= 1'b1;
         end
      end

      assign out = en ? (hit & src) : src;
   end else begin : g_pass
      logic unused_tmr;
      assign unused_tmr = ^{clk, rst_n, en, reload, restart};
      assign out = src;
   end
endmodule

// File: rtl/lsr_rx_path.sv
module lsr_rx_path
   import uart_lsr_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_en,
   input  logic          ctl_wr,
   input  logic [DW-1:0] ctl_data,
   input  logic          ctl_flag_wr,
   input  logic [EW-1:0] ctl_flags,
   input  logic          host_rd,
   input  logic          host_lsr_rd,
   output logic [DW-1:0] host_data,
   output logic [EW-1:0] head_err,
   output logic          data_rdy,
   output logic          overrun,
   output logic          err_any,
   output logic          accept
);
   rx_ent_t       in_ent, head;
   logic [EW-1:0] shadow;
   logic [CW-1:0] cnt, cap, err_cnt;
   logic          take;

   assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
   assign accept = ctl_wr && (cnt < cap);
   assign take   = host_rd && (cnt != '0);
   assign in_ent = '{err: shadow, data: ctl_data};

   lsr_fifo #(.W($bits(rx_ent_t)), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .din   (in_ent),
      .pop   (take),
      .dout  (head),
      .count (cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow  <= '0;
         overrun <= 1'b0;
         err_cnt <= '0;
      end else begin
         if (ctl_flag_wr)    shadow <= ctl_flags;
         else if (ctl_wr)    shadow <= '0;
         if (ctl_wr && !accept) overrun <= 1'b1;
         else if (host_lsr_rd)  overrun <= 1'b0;
         case ({accept && (shadow != '0), take && (head.err != '0)})
            2'b10:   err_cnt <= err_cnt + CW'(1);
            2'b01:   err_cnt <= err_cnt - CW'(1);
            default: err_cnt <= err_cnt;
         endcase
      end
   end

   assign host_data = head.data;
   assign data_rdy  = (cnt != '0);
   assign head_err  = data_rdy ? head.err : '0;
   assign err_any   = (err_cnt != '0);
endmodule

// File: rtl/lsr_tx_path.sv
module lsr_tx_path
   import uart_lsr_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_en,
   input  logic [1:0]    trig_sel,
   input  logic          host_wr,
   input  logic [DW-1:0] host_data,
   input  logic          ctl_rd,
   output logic [DW-1:0] ctl_data,
   output logic [CW-1:0] level,
   output logic          thre
);
   logic [CW-1:0] cap, trig, nxt;
   logic          put, take;

   assign cap  = fifo_en ? CW'(DEPTH) : CW'(1);
   assign trig = fifo_en ? CW'(trig_level(trig_sel)) : CW'(1);
   assign put  = host_wr && (level < cap);
   assign take = ctl_rd && (level != '0);
   assign nxt  = level + CW'(put) - CW'(take);

   lsr_fifo #(.W(DW), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (put),
      .din   (host_data),
      .pop   (take),
      .dout  (ctl_data),
      .count (level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            thre <= 1'b1;
      else if (nxt == '0)    thre <= 1'b1;
      else if (nxt >= trig)  thre <= 1'b0;
   end
endmodule

// File: rtl/uart_lsr_emu.sv
module uart_lsr_emu
   import uart_lsr_pkg::*;
#(
   parameter int RX_DEPTH   = 16,
   parameter int TX_DEPTH   = 16,
   parameter int TMR_W      = 16,
   parameter int RX_HAS_TMR = 1,
   parameter int TX_HAS_TMR = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fifo_en,
   input  logic [1:0]                    tx_trig_sel,
   input  logic                          rx_tmr_en,
   input  logic [TMR_W-1:0]              rx_tmr_reload,
   input  logic                          tx_tmr_en,
   input  logic [TMR_W-1:0]              tx_tmr_reload,
   input  logic                          host_tx_wr,
   input  logic [7:0]                    host_tx_data,
   input  logic                          host_rx_rd,
   input  logic                          host_lsr_rd,
   output logic [7:0]                    host_rx_data,
   output logic [7:0]                    host_lsr,
   input  logic                          ctl_rx_wr,
   input  logic [7:0]                    ctl_rx_data,
   input  logic                          ctl_lsr_wr,
   input  logic [2:0]                    ctl_err_flags,
   input  logic                          ctl_tx_rd,
   output logic [7:0]                    ctl_tx_data,
   output logic [$clog2(TX_DEPTH+1)-1:0] ctl_tx_level,
   output logic [7:0]                    ctl_lsr
);
   if (TX_DEPTH < 14) begin : g_bad_tx
      $error("uart_lsr_emu: TX_DEPTH must cover the largest trigger level");
   end
   if (RX_DEPTH < 1 || TMR_W < 1) begin : g_bad_rx
      $error("uart_lsr_emu: RX_DEPTH and TMR_W must be positive");
   end

   logic [EW-1:0] head_err;
   logic dr_raw, ovr, err_any, rx_acc, thre_raw, dr_host, thre_host, err_bit;

   lsr_rx_path #(.DEPTH(RX_DEPTH)) u_rx (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
      .ctl_wr(ctl_rx_wr), .ctl_data(ctl_rx_data),
      .ctl_flag_wr(ctl_lsr_wr), .ctl_flags(ctl_err_flags),
      .host_rd(host_rx_rd), .host_lsr_rd(host_lsr_rd),
      .host_data(host_rx_data), .head_err(head_err), .data_rdy(dr_raw),
      .overrun(ovr), .err_any(err_any), .accept(rx_acc)
   );

   lsr_tx_path #(.DEPTH(TX_DEPTH)) u_tx (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(tx_trig_sel),
      .host_wr(host_tx_wr), .host_data(host_tx_data), .ctl_rd(ctl_tx_rd),
      .ctl_data(ctl_tx_data), .level(ctl_tx_level), .thre(thre_raw)
   );

   lsr_delay #(.HAS_TMR(RX_HAS_TMR), .TMR_W(TMR_W)) u_rx_dly (
      .clk(clk), .rst_n(rst_n), .en(rx_tmr_en), .reload(rx_tmr_reload),
      .src(dr_raw), .restart(rx_acc), .out(dr_host)
   );

   lsr_delay #(.HAS_TMR(TX_HAS_TMR), .TMR_W(TMR_W)) u_tx_dly (
      .clk(clk), .rst_n(rst_n), .en(tx_tmr_en), .reload(tx_tmr_reload),
      .src(thre_raw), .restart(1'b0), .out(thre_host)
   );

   assign err_bit  = fifo_en & err_any;
   assign host_lsr = {err_bit, thre_host, thre_host, head_err, ovr, dr_host};
   assign ctl_lsr  = {err_bit, thre_raw,  thre_raw,  head_err, ovr, dr_raw};
endmodule

// File: rtl/uart_lsr_chk.sv
module uart_lsr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fifo_en,
   input logic [1:0] tx_trig_sel,
   input logic       host_tx_wr,
   input logic       host_rx_rd,
   input logic       host_lsr_rd,
   input logic       ctl_rx_wr,
   input logic [7:0] host_lsr,
   input logic [7:0] ctl_lsr
);
   // R3
   overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_lsr[1]) |-> $past(ctl_rx_wr));

   // R4
   overrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_lsr[1] && host_lsr_rd && !ctl_rx_wr |=> !host_lsr[1]);

   // R2
   ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_lsr[0]) |-> $past(host_rx_rd));

   // R9
   ready_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_lsr[0] |-> ctl_lsr[0]);

   // R10
   empty_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_lsr[5] |-> ctl_lsr[5]);

   // R7
   empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_lsr[5]) && ($past(fifo_en) == $past(fifo_en, 2))
      && ($past(tx_trig_sel) == $past(tx_trig_sel, 2)) |-> $past(host_tx_wr));

   // R6
   err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_lsr[7]) && fifo_en && $past(fifo_en) |-> $past(host_rx_rd));
endmodule

bind uart_lsr_emu uart_lsr_chk u_chk (.*);

// File: tb/uart_lsr_emu_bench.sv
module uart_lsr_emu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fifo_en = 1'b0;
   logic [1:0]  tx_trig_sel = 2'd0;
   logic        rx_tmr_en = 1'b0, tx_tmr_en = 1'b0;
   logic [15:0] rx_tmr_reload = '0, tx_tmr_reload = '0;
   logic        host_tx_wr = 1'b0, host_rx_rd = 1'b0, host_lsr_rd = 1'b0;
   logic [7:0]  host_tx_data = '0;
   logic [7:0]  host_rx_data, host_lsr;
   logic        ctl_rx_wr = 1'b0, ctl_lsr_wr = 1'b0, ctl_tx_rd = 1'b0;
   logic [7:0]  ctl_rx_data = '0;
   logic [2:0]  ctl_err_flags = '0;
   logic [7:0]  ctl_tx_data, ctl_lsr;
   logic [4:0]  ctl_tx_level;

   always #5 clk = ~clk;

   uart_lsr_emu u_uart_lsr_emu (.*);

   int n_chk = 0, n_fail = 0;
   int rx_cnt_m = 0, tx_cnt_m = 0;
   logic [2:0]  sh_m = '0;
   logic [10:0] rxq[$];
   logic [7:0]  txq[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ctl_flag(input logic [2:0] f);
      ctl_lsr_wr = 1'b1; ctl_err_flags = f;
      @(negedge clk);
      ctl_lsr_wr = 1'b0;
      sh_m = f;
   endtask

   // driver: pushes the expected entry when the model says it fits
   task automatic ctl_send(input logic [7:0] d);
      int cap = fifo_en ? 16 : 1;
      ctl_rx_wr = 1'b1; ctl_rx_data = d;
      @(negedge clk);
      ctl_rx_wr = 1'b0;
      if (rx_cnt_m < cap) begin
         rxq.push_back({sh_m, d});
         rx_cnt_m++;
      end
      sh_m = '0;
   endtask

   // monitor side: pops the expected entry and compares the head
   task automatic host_pop(input string tag);
      logic [10:0] e = rxq.pop_front();
      chk({tag, " data"}, host_rx_data, e[7:0]);
      chk({tag, " flags"}, host_lsr[4:2], e[10:8]);
      host_rx_rd = 1'b1;
      @(negedge clk);
      host_rx_rd = 1'b0;
      rx_cnt_m--;
   endtask

   task automatic host_put(input logic [7:0] d);
      int cap = fifo_en ? 16 : 1;
      host_tx_wr = 1'b1; host_tx_data = d;
      @(negedge clk);
      host_tx_wr = 1'b0;
      if (tx_cnt_m < cap) begin
         txq.push_back(d);
         tx_cnt_m++;
      end
   endtask

   task automatic ctl_take(input string tag);
      chk(tag, ctl_tx_data, txq.pop_front());
      ctl_tx_rd = 1'b1;
      @(negedge clk);
      ctl_tx_rd = 1'b0;
      tx_cnt_m--;
   endtask

   task automatic lsr_read();
      host_lsr_rd = 1'b1;
      @(negedge clk);
      host_lsr_rd = 1'b0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 host status", host_lsr, 8'h60);
      chk("R1 ctl status", ctl_lsr, 8'h60);
      chk("R1 tx level", ctl_tx_level, 0);

      // character mode receive, overrun and clear
      ctl_send(8'hA5);
      chk("R2 ready set", host_lsr[0], 1);
      ctl_send(8'h3C);
      chk("R3 overrun char mode", host_lsr[1], 1);
      lsr_read();
      chk("R4 overrun cleared", host_lsr[1], 0);
      host_pop("R3 held byte");
      chk("R2 ready cleared", host_lsr[0], 0);

      // R5 shadow flags ride along once
      ctl_flag(3'b101);
      chk("R5 shadow not yet visible", host_lsr[4:2], 3'b000);
      ctl_send(8'h11);
      host_pop("R5 flagged char");
      ctl_send(8'h22);
      host_pop("R5 clean char");
      chk("R6 no fifo error bit in char mode", host_lsr[7], 0);

      // R7 character mode transmit empty
      host_put(8'h77);
      chk("R7 thr full", host_lsr[6:5], 2'b00);
      ctl_take("R7 byte");
      chk("R7 thr empty", host_lsr[6:5], 2'b11);

      // FIFO mode fill, overrun, ordering
      fifo_en = 1'b1;
      idle(1);
      for (int i = 0; i < 17; i++) ctl_send(8'(i * 7 + 1));
      chk("R3 overrun fifo full", host_lsr[1], 1);
      lsr_read();
      chk("R4 overrun cleared fifo", host_lsr[1], 0);
      for (int i = 0; i < 16; i++) host_pop("R11 order");
      chk("R2 ready cleared fifo", host_lsr[0], 0);

      // R6 per-entry flags and bit 7
      ctl_send(8'h40);
      ctl_flag(3'b010);
      ctl_send(8'h41);
      ctl_send(8'h42);
      chk("R6 err bit set", host_lsr[7], 1);
      chk("R6 clean head", host_lsr[4:2], 3'b000);
      host_pop("R6 first");
      chk("R6 err bit held", host_lsr[7], 1);
      host_pop("R6 flagged head");
      chk("R6 err bit cleared", host_lsr[7], 0);
      host_pop("R6 last");

      // R8 trigger hysteresis, select 1 -> 4
      tx_trig_sel = 2'd1;
      for (int i = 0; i < 3; i++) host_put(8'(8'h80 + i));
      chk("R8 below trigger", host_lsr[5], 1);
      host_put(8'h83);
      chk("R8 trigger reached", host_lsr[5], 0);
      chk("R8 level", ctl_tx_level, 4);
      for (int i = 0; i < 3; i++) ctl_take("R11 tx order");
      chk("R8 held low above empty", host_lsr[5], 0);
      ctl_take("R11 tx order");
      chk("R8 empty again", host_lsr[5], 1);

      // R9 receive delay with restart, reload 5
      rx_tmr_reload = 16'd5;
      rx_tmr_en = 1'b1;
      idle(1);
      ctl_send(8'h55);
      chk("R9 ctl copy immediate", ctl_lsr[0], 1);
      chk("R9 host copy pending", host_lsr[0], 0);
      idle(2);
      ctl_send(8'h56);
      idle(5);
      chk("R9 restart extends delay", host_lsr[0], 0);
      idle(1);
      chk("R9 host copy set", host_lsr[0], 1);
      host_pop("R9 first");
      host_pop("R9 second");
      chk("R9 cleared on last read", host_lsr[0], 0);
      rx_tmr_en = 1'b0;

      // R10 transmit delay, reload 3, character mode
      fifo_en = 1'b0;
      tx_tmr_reload = 16'd3;
      tx_tmr_en = 1'b1;
      idle(6);
      host_put(8'h99);
      chk("R10 host bit clears at once", host_lsr[5], 0);
      idle(2);
      ctl_take("R10 byte");
      chk("R10 ctl copy immediate", ctl_lsr[5], 1);
      chk("R10 host copy pending", host_lsr[5], 0);
      idle(3);
      chk("R10 still pending", host_lsr[5], 0);
      idle(1);
      chk("R10 host copy set", host_lsr[5], 1);

      summary();
      $finish;
   end
endmodule